// File: doc/BRIEF.md
# I2C Master Four-Command Sequencer

This block drives a byte-level I2C master engine through one fixed transaction on a single slave address: a write, then a read, then a second write, then a second read. The engine raises its busy flag each time it accepts a command. The sequencer does not use a per-command handshake. It counts the low-to-high transitions of that flag, and each count tells it that the command on offer has been taken and that the next one may be presented.

The two bytes returned by the reads are gathered into one result word. The first read fills the upper half and the second read fills the lower half. A one-cycle done pulse marks the point where the word is complete.

A start pulse in the idle state latches the slave address and both write bytes. The caller may therefore change those inputs while the transaction runs. The counter, the previous-busy register, the result register and the state all sit in clocked logic, so the engine's busy input never feeds back through combinational paths.

Top module: `i2cs_chain_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the sequencer returns to idle. In idle, `eng_en` and `done` are 0, `result` is 0 and the command counter is cleared.
- R2: A `start` sampled high in idle latches `slave_addr`, `wr_byte_a` and `wr_byte_b`. From the next cycle on, `eng_en` is 1, `eng_rnw` is 0 (0 = write, 1 = read), `eng_addr` shows the latched address and `eng_wdata` shows the latched first byte.
- R3: The counter advances only when `eng_busy` is 1 at a clock edge after being 0 at the edge before, and only while a transaction runs. Busy held high over many cycles counts once. The outputs do not change between such transitions.
- R4: After the first busy rise, `eng_rnw` becomes 1 while the address stays the same.
- R5: After the second busy rise, `eng_rnw` is 0 and `eng_wdata` shows the second byte. In every cycle of this phase in which busy is sampled low, `eng_rd_data` is written into `result[15:8]`.
- R6: After the third busy rise, `eng_rnw` is 1.
- R7: After the fourth busy rise, `eng_en` drops to 0 and `eng_rnw` stays 1. At the first edge in that phase where busy is low, `eng_rd_data` is written into `result[7:0]` and the sequencer goes idle. In the following cycle `done` is 1, for exactly one cycle.
- R8: While a transaction runs, `start` has no effect, including on the latched address and bytes. While idle, busy rises are not counted, and `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transaction (sampled in idle only) |
| slave_addr | input | ADDR_W | Slave address for all four commands |
| wr_byte_a | input | DATA_W | Byte for the first write |
| wr_byte_b | input | DATA_W | Byte for the second write |
| eng_busy | input | 1 | Engine busy flag |
| eng_rd_data | input | DATA_W | Engine read data |
| eng_en | output | 1 | Engine enable (command on offer) |
| eng_addr | output | ADDR_W | Address presented to the engine |
| eng_rnw | output | 1 | 1 = read, 0 = write |
| eng_wdata | output | DATA_W | Write byte presented to the engine |
| result | output | 2*DATA_W | First read byte in the upper half, second in the lower half |
| done | output | 1 | One-cycle pulse when the result is complete |

## Verification
The hardest situations to reach are those where the busy flag moves outside the rhythm of a well-behaved engine. These include rises while idle, a reset in the middle of a command, and a one-cycle low gap between chained commands that the edge detector must still resolve as a new rise.

The bench models the engine with a programmable command length and gap, including a gap of zero. It adds a separate manual busy source to inject pulses while idle. It also pulses reset and start in the middle of transactions.

A behavioural reference, updated on every clock, predicts all outputs. The commands the engine accepts are logged and checked against the expected write, read, write, read order.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   // number of commands in one chained transaction
   localparam int unsigned CMD_COUNT = 4;
   localparam int unsigned STEP_W    = $clog2(CMD_COUNT + 1);

   typedef logic [STEP_W-1:0] step_t;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   // step value = number of busy rises seen so far in the transaction
   localparam step_t STEP_WR_A = step_t'(0);
   localparam step_t STEP_RD_A = step_t'(1);
   localparam step_t STEP_WR_B = step_t'(2);
   localparam step_t STEP_RD_B = step_t'(3);
   localparam step_t STEP_LAST = step_t'(CMD_COUNT);

endpackage

// File: rtl/i2cs_rise_counter.sv
module i2cs_rise_counter
   import i2cs_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  count_en,
   input  logic  clear,
   input  logic  busy,
   output logic  rise,
   output step_t step
);

   logic busy_q;

   // previous busy value, registered every cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
      end else begin
         busy_q <= busy;
      end
   end

   assign rise = busy & ~busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         step <= STEP_WR_A;
      end else if (count_en && rise && (step != STEP_LAST)) begin
         step <= step_t'(step + step_t'(1));
      end
   end

endmodule

// File: rtl/i2cs_cmd_decode.sv
module i2cs_cmd_decode
   import i2cs_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8
) (
   input  logic              run,
   input  step_t             step,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] byte_a_q,
   input  logic [DATA_W-1:0] byte_b_q,
   output logic              en,
   output logic              rnw,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);

   always_comb begin
      en    = run && (step < STEP_LAST);
      // read on the odd steps; stays read after the final command
      rnw   = run && ((step == STEP_RD_A) || (step >= STEP_RD_B));
      wdata = (step >= STEP_WR_B) ? byte_b_q : byte_a_q;
      addr  = addr_q;
   end

endmodule

// File: rtl/i2cs_result_cap.sv
module i2cs_result_cap #(
   parameter int unsigned DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_hi,
   input  logic                cap_lo,
   input  logic [DATA_W-1:0]   rd_data,
   output logic [2*DATA_W-1:0] result
);

   localparam int unsigned RES_W = 2 * DATA_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
      end else begin
         if (cap_hi) begin
            result[RES_W-1:DATA_W] <= rd_data;
         end
         if (cap_lo) begin
            result[DATA_W-1:0] <= rd_data;
         end
      end
   end

endmodule

// File: rtl/i2cs_chain_seq.sv
module i2cs_chain_seq
   import i2cs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned DATA_W    = 8,
   parameter bit          LATCH_CMD = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   slave_addr,
   input  logic [DATA_W-1:0]   wr_byte_a,
   input  logic [DATA_W-1:0]   wr_byte_b,
   input  logic                eng_busy,
   input  logic [DATA_W-1:0]   eng_rd_data,
   output logic                eng_en,
   output logic [ADDR_W-1:0]   eng_addr,
   output logic                eng_rnw,
   output logic [DATA_W-1:0]   eng_wdata,
   output logic [2*DATA_W-1:0] result,
   output logic                done
);

   localparam int unsigned RES_W = 2 * DATA_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr_w
      $error("i2cs_chain_seq: ADDR_W must lie in 1..10");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("i2cs_chain_seq: DATA_W must be at least 1");
   end
   if (RES_W != 2 * DATA_W) begin : g_bad_res_w
      $error("i2cs_chain_seq: result width mismatch");
   end

   seq_state_e        state_q;
   logic              run;
   logic              rise;
   step_t             step;
   logic              finish;
   logic              cap_hi;
   logic              accept;
   logic              done_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] byte_a_q;
   logic [DATA_W-1:0] byte_b_q;

   assign run    = (state_q == SEQ_RUN);
   assign accept = (state_q == SEQ_IDLE) && start;
   assign cap_hi = run && (step == STEP_WR_B) && !eng_busy && !rise;
   assign finish = run && (step == STEP_LAST) && !eng_busy && !rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         unique case (state_q)
            SEQ_IDLE: if (start)  state_q <= SEQ_RUN;
            SEQ_RUN:  if (finish) state_q <= SEQ_IDLE;
            default:              state_q <= SEQ_IDLE;
         endcase
      end
   end

   // command operands: held from the start pulse, or passed straight through
   if (LATCH_CMD) begin : g_latch_cmd
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q   <= '0;
            byte_a_q <= '0;
            byte_b_q <= '0;
         end else if (accept) begin
            addr_q   <= slave_addr;
            byte_a_q <= wr_byte_a;
            byte_b_q <= wr_byte_b;
         end
      end
   end else begin : g_pass_cmd
      assign addr_q   = slave_addr;
      assign byte_a_q = wr_byte_a;
      assign byte_b_q = wr_byte_b;
   end

   i2cs_rise_counter u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (run),
      .clear    (finish),
      .busy     (eng_busy),
      .rise     (rise),
      .step     (step)
   );

   i2cs_cmd_decode #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_decode (
      .run      (run),
      .step     (step),
      .addr_q   (addr_q),
      .byte_a_q (byte_a_q),
      .byte_b_q (byte_b_q),
      .en       (eng_en),
      .rnw      (eng_rnw),
      .addr     (eng_addr),
      .wdata    (eng_wdata)
   );

   i2cs_result_cap #(
      .DATA_W (DATA_W)
   ) u_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_hi  (cap_hi),
      .cap_lo  (finish),
      .rd_data (eng_rd_data),
      .result  (result)
   );

   assign done = done_q;

endmodule

// File: rtl/i2cs_chain_seq_chk.sv
module i2cs_chain_seq_chk #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eng_busy,
   input logic              eng_en,
   input logic              eng_rnw,
   input logic [ADDR_W-1:0] eng_addr,
   input logic [DATA_W-1:0] eng_wdata,
   input logic              done
);

   // R1: first cycle out of reset is idle
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!eng_en && !done));

   // R3: without a busy rise, the command on offer stays the same
   a_r3_hold_without_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_en && !(eng_busy && !$past(eng_busy)))
      |=> ($stable(eng_rnw) && $stable(eng_wdata) && $stable(eng_addr)));

   // R7: done lasts a single cycle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: enable is already low when done is seen
   a_r7_done_en_low: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !eng_en);

   // R4: the address does not move when the direction turns to read
   a_r4_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(eng_rnw) && eng_en && $past(eng_en)) |-> $stable(eng_addr));

endmodule

bind i2cs_chain_seq i2cs_chain_seq_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .eng_busy  (eng_busy),
   .eng_en    (eng_en),
   .eng_rnw   (eng_rnw),
   .eng_addr  (eng_addr),
   .eng_wdata (eng_wdata),
   .done      (done)
);

// File: tb/tb_i2cs_chain_seq.sv
module tb_i2cs_chain_seq;

   localparam int AW = 7;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] slave_addr = '0;
   logic [DW-1:0] wr_byte_a = '0;
   logic [DW-1:0] wr_byte_b = '0;
   logic          eng_busy;
   logic [DW-1:0] eng_rd_data = '0;
   logic          eng_en;
   logic [AW-1:0] eng_addr;
   logic          eng_rnw;
   logic [DW-1:0] eng_wdata;
   logic [2*DW-1:0] result;
   logic          done;

   always #5 clk = ~clk;

   i2cs_chain_seq #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .slave_addr(slave_addr),
      .wr_byte_a(wr_byte_a), .wr_byte_b(wr_byte_b), .eng_busy(eng_busy),
      .eng_rd_data(eng_rd_data), .eng_en(eng_en), .eng_addr(eng_addr),
      .eng_rnw(eng_rnw), .eng_wdata(eng_wdata), .result(result), .done(done)
   );

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   int done_seen = 0;

   // engine model state
   logic          eng_busy_r = 1'b0;
   logic          busy_man = 1'b0;
   logic          cur_rnw = 1'b0;
   logic [DW-1:0] pending = '0;
   int            left = 0;
   int            gap_left = 0;
   int            len_cfg = 3;
   int            gap_cfg = 1;
   logic [DW-1:0] rd_q[$];
   logic [AW+DW:0] log_q[$];

   assign eng_busy = eng_busy_r | busy_man;

   // reference model state
   logic          m_run = 1'b0;
   int            m_cnt = 0;
   logic          m_prev = 1'b0;
   logic [2*DW-1:0] m_res = '0;
   logic          m_done = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_w0 = '0;
   logic [DW-1:0] m_w1 = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      logic rise;
      cycles++;
      if (!rst_n) begin
         m_run = 1'b0; m_cnt = 0; m_prev = 1'b0; m_res = '0; m_done = 1'b0;
         m_addr = '0; m_w0 = '0; m_w1 = '0;
      end else begin
         rise = eng_busy && !m_prev;
         m_prev = eng_busy;
         m_done = 1'b0;
         if (!m_run) begin
            if (start) begin
               m_run = 1'b1; m_cnt = 0;
               m_addr = slave_addr; m_w0 = wr_byte_a; m_w1 = wr_byte_b;
            end
         end else if (rise) begin
            if (m_cnt < 4) m_cnt++;
         end else if (!eng_busy && m_cnt == 2) begin
            m_res[2*DW-1:DW] = eng_rd_data;
         end else if (!eng_busy && m_cnt == 4) begin
            m_res[DW-1:0] = eng_rd_data;
            m_done = 1'b1; m_run = 1'b0; m_cnt = 0;
         end
      end
   end

   // compare on the falling edge, then advance the engine model
   always @(negedge clk) begin
      string tag;
      logic e_en, e_rnw;
      logic [DW-1:0] e_wd;
      if (!m_run) tag = "R1/R8 idle";
      else if (m_cnt == 0) tag = "R2 step0";
      else if (m_cnt == 1) tag = "R4 step1";
      else if (m_cnt == 2) tag = "R5 step2";
      else if (m_cnt == 3) tag = "R6 step3";
      else tag = "R7 step4";
      e_en  = m_run && (m_cnt < 4);
      e_rnw = m_run && (m_cnt == 1 || m_cnt >= 3);
      e_wd  = (m_run && m_cnt >= 2) ? m_w1 : m_w0;
      chk({tag, " en/rnw/done"}, {29'd0, eng_en, eng_rnw, done}, {29'd0, e_en, e_rnw, m_done});
      chk({tag, " addr/wdata"}, {17'd0, eng_addr, eng_wdata}, {17'd0, m_addr, e_wd});
      chk({tag, " result"}, {16'd0, result}, {16'd0, m_res});
      if (done) done_seen++;
      // engine model
      if (!rst_n) begin
         eng_busy_r = 1'b0; gap_left = 0; left = 0;
      end else if (!eng_busy_r) begin
         if (gap_left > 0) gap_left--;
         else if (eng_en) begin
            log_q.push_back({eng_rnw, eng_addr, eng_wdata});
            cur_rnw = eng_rnw;
            if (eng_rnw) pending = (rd_q.size() > 0) ? rd_q.pop_front() : 8'h00;
            eng_busy_r = 1'b1; left = len_cfg;
         end
      end else begin
         if (left > 1) left--;
         else begin
            eng_busy_r = 1'b0;
            if (cur_rnw) eng_rd_data = pending;
            gap_left = gap_cfg;
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cycles == 150000) begin
         failures++;
         $display("FAIL watchdog R7 actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_txn(input logic [AW-1:0] a, input logic [DW-1:0] w0,
                          input logic [DW-1:0] w1, input logic [DW-1:0] ra,
                          input logic [DW-1:0] rb, input int len, input int gap,
                          input bit disturb);
      int d0;
      int n;
      log_q.delete();
      rd_q.delete();
      rd_q.push_back(ra);
      rd_q.push_back(rb);
      len_cfg = len;
      gap_cfg = gap;
      d0 = done_seen;
      @(negedge clk);
      slave_addr = a; wr_byte_a = w0; wr_byte_b = w1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         // R8: changed operands and a second start during the run
         slave_addr = ~a; wr_byte_a = ~w0; wr_byte_b = ~w1;
         repeat (4) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (done_seen == d0 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
      chk("R7 single done per transaction", done_seen - d0, 1);
      chk("R5/R7 result word", {16'd0, result}, {16'd0, ra, rb});
      chk("R3 command count", log_q.size(), 4);
      if (log_q.size() == 4) begin
         chk("R2 first command write", {15'd0, log_q[0]}, {15'd0, 1'b0, a, w0});
         chk("R4 second command read", {24'd0, log_q[1][AW+DW:DW]}, {24'd0, 1'b1, a});
         chk("R5 third command write", {15'd0, log_q[2]}, {15'd0, 1'b0, a, w1});
         chk("R6 fourth command read", {24'd0, log_q[3][AW+DW:DW]}, {24'd0, 1'b1, a});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset enable", {31'd0, eng_en}, 32'd0);
      chk("R1 reset result", {16'd0, result}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_txn(7'h2A, 8'h11, 8'h22, 8'hA5, 8'h3C, 3, 1, 1'b0);
      run_txn(7'h51, 8'hF0, 8'h0F, 8'h81, 8'h7E, 1, 0, 1'b0);
      run_txn(7'h7F, 8'hC3, 8'h96, 8'h00, 8'hFF, 7, 4, 1'b1);

      // R8: busy pulses while idle are not counted; result is held
      repeat (2) begin
         @(negedge clk); busy_man = 1'b1;
         repeat (3) @(negedge clk);
         busy_man = 1'b0;
         @(negedge clk);
      end
      chk("R8 idle rises leave enable low", {31'd0, eng_en}, 32'd0);
      chk("R8 result held in idle", {16'd0, result}, {16'd0, 8'h00, 8'hFF});
      run_txn(7'h05, 8'h5A, 8'hA5, 8'h12, 8'h34, 2, 2, 1'b0);

      // R1: reset in the middle of the second command
      len_cfg = 6; gap_cfg = 1;
      rd_q.delete(); rd_q.push_back(8'h99);
      @(negedge clk);
      slave_addr = 7'h33; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (12) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 mid-run reset enable", {31'd0, eng_en}, 32'd0);
      chk("R1 mid-run reset result", {16'd0, result}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      run_txn(7'h44, 8'h01, 8'h02, 8'hDE, 8'hAD, 4, 0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule